// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel PCM samples into a serial audio stream. It sends one data bit per bit clock, together with a word-select level or a frame-sync pulse that it generates itself. The framing is chosen at run time from four formats. Three are two-slot formats (I2S, left justified and right justified). The fourth is a time-division format with a fixed number of slots per frame. Word size and slot width are chosen from 8, 16, 24 and 32 bits, and so is the number of active channels.

The bit clock comes from elsewhere and enters as `bclk`. The block samples it on its own system clock `clk` and acts on its edges, so `clk` must run at least eight times as fast as `bclk`. Samples arrive through a valid/ready port, one word per active channel per frame, in slot order. Configuration is copied into the block only while `enable` is low. Raising `enable` starts a frame at the next launch edge. Lowering it lets the current frame finish and then the line goes quiet.

Top module: `pcm_serializer`

## Requirements
- R1: I2S format (`cfg_format`=0). Word select is low for slot 0 (left) and high for slot 1 (right), and each level lasts one slot. The MSB of each slot follows its word-select edge by one bit clock. The LSB of the right word is sent at position 0 of the next frame.
- R2: Left-justified format (`cfg_format`=1). The MSB is sent on the same bit clock as the word-select edge. The word's bits come first and zeros fill the rest of the slot.
- R3: Right-justified format (`cfg_format`=2). The word is sent at the end of the slot, so its LSB is the last bit before the next word-select edge. Leading bits of the slot are zero.
- R4: TDM format (`cfg_format`=3). A frame holds TDM_SLOTS slots. Frame sync is high for exactly the first bit of the frame, and the MSB of slot 0 is sent on that same bit. Slots at or above the channel count carry zeros.
- R5: The word-size code (`cfg_word`) and the slot code (`cfg_slot`) both map 0,1,2,3 to 8,16,24,32 bits. The slot width used is the larger of the two.
- R6: In the two-slot formats the channel count is capped at 2. With one channel, the right slot carries zeros and only one sample is taken per frame.
- R7: Data and word select change on the falling edge of `bclk`, so a receiver samples them on the rising edge. With `cfg_bclk_inv`=1 they change on the rising edge instead.
- R8: `cfg_fs_inv`=1 inverts word select and frame sync, including their level while the block is stopped.
- R9: A sample is accepted (`s_valid` and `s_ready` both high) at the first bit of each active slot, one sample per active slot. The word sits in the low bits of `s_data`. `s_ready` lasts one `clk` cycle.
- R10: If `s_valid` is low when a slot starts, the slot sends zeros and `underflow` is set. It stays set until the next start.
- R11: A start begins at frame position 0 on the first launch edge after `enable` rises. A stop takes effect at the end of the frame that is running. While stopped, `sd_out` is 0 and word select sits at its inactive level. After reset all outputs are low.
- R12: While the block is running, changes on the configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request |
| cfg_format | input | 2 | 0 I2S, 1 left justified, 2 right justified, 3 TDM |
| cfg_word | input | 2 | Word-size code: 8, 16, 24 or 32 bits |
| cfg_slot | input | 2 | Slot-width code (same map; never smaller than the word) |
| cfg_chans | input | CHAN_W | Active channel count |
| cfg_bclk_inv | input | 1 | Launch data on the rising `bclk` edge |
| cfg_fs_inv | input | 1 | Invert word select / frame sync |
| bclk | input | 1 | Bit clock, sampled on `clk` |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample, right aligned |
| s_ready | output | 1 | Sample taken this cycle |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select or frame sync |
| underflow | output | 1 | Sticky empty-slot flag |

## Verification
A frame or slot counter that is off by one shows within one frame: the word-select edge moves away from the expected bit, or the MSB slides one position, and the bit-by-bit comparison catches it on the next receiver sample edge. A mistake in sample fetch or channel gating shows as a wrong bit in the first slot it touches. It also leaves the number of samples taken different from the number offered, and that is checked when each run ends. Stop handling and configuration freezing are checked at the idle bits after each run, and in a run whose configuration inputs change partway through a frame.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

  localparam int SAMPLE_W = 32;
  localparam int POS_W    = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_TDM   = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] word_code;
    logic [1:0] slot_code;
    logic       bclk_inv;
    logic       fs_inv;
  } cfg_t;

  // index of the last bit in a word: 8*(code+1)-1
  function automatic logic [POS_W-1:0] word_last(cfg_t c);
    return POS_W'({c.word_code, 3'b111});
  endfunction

  // slot is never narrower than the word
  function automatic logic [POS_W-1:0] slot_last(cfg_t c);
    logic [1:0] code;
    code = (c.slot_code > c.word_code) ? c.slot_code : c.word_code;
    return POS_W'({code, 3'b111});
  endfunction

endpackage

// File: rtl/pcm_ser_ctrl.sv
module pcm_ser_ctrl
  import pcm_ser_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  cfg_t          cfg_in,
  input  logic [CW-1:0] chans_in,
  input  logic          bclk,
  input  logic          frame_last,
  output cfg_t          cfg_q,
  output logic [CW-1:0] chans_q,
  output logic          launch,
  output logic          running,
  output logic          start
);

  logic [2:0] bsync;

  always_ff @(posedge clk) begin
    if (rst) bsync <= '0;
    else     bsync <= {bsync[1:0], bclk};
  end

  // launch edge: falling by default, rising when inverted
  assign launch = (bsync[1] ^ bsync[2]) & (bsync[1] == cfg_q.bclk_inv);
  assign start  = launch & ~running & enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
    end else if (launch && running && frame_last && !enable) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '{fmt: FMT_I2S, word_code: 2'd0, slot_code: 2'd0,
                   bclk_inv: 1'b0, fs_inv: 1'b0};
      chans_q <= CW'(2);
    end else if (!enable && !running) begin
      cfg_q   <= cfg_in;
      chans_q <= chans_in;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    running |=> ($stable(cfg_q) && $stable(chans_q))); // R12

  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch); // R7

endmodule

// File: rtl/pcm_ser_slots.sv
module pcm_ser_slots
  import pcm_ser_pkg::*;
#(
  parameter int TDM_SLOTS = 8,
  parameter int KW        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             running,
  input  logic             start,
  input  cfg_t             cfg_q,
  output logic             frame_last,
  output logic [KW-1:0]    dslot,
  output logic [POS_W-1:0] dbit,
  output logic             ws_out
);

  logic [KW-1:0]    k_q;
  logic [POS_W-1:0] p_q;
  logic [KW-1:0]    ns_last;
  logic [POS_W-1:0] s_last;
  logic             emit;
  logic             delayed;
  logic             ws_raw;

  assign emit    = running | start;
  assign s_last  = slot_last(cfg_q);
  assign ns_last = (cfg_q.fmt == FMT_TDM) ? KW'(TDM_SLOTS - 1) : KW'(1);
  assign delayed = (cfg_q.fmt == FMT_I2S);

  assign frame_last = (k_q == ns_last) && (p_q == s_last);
  assign ws_raw     = (cfg_q.fmt == FMT_TDM) ? ((k_q == '0) && (p_q == '0))
                                             : (k_q != '0);

  // frame-position counters (drive word select)
  always_ff @(posedge clk) begin
    if (rst) begin
      k_q <= '0;
      p_q <= '0;
    end else if (launch && emit) begin
      if (p_q == s_last) begin
        p_q <= '0;
        k_q <= (k_q == ns_last) ? '0 : k_q + 1'b1;
      end else begin
        p_q <= p_q + 1'b1;
      end
    end else if (!running) begin
      k_q <= '0;
      p_q <= '0;
    end
  end

  // data-position counters, one bit behind in I2S format
  always_ff @(posedge clk) begin
    if (rst) begin
      dslot <= '0;
      dbit  <= '0;
    end else if (launch && emit) begin
      if (dbit == s_last) begin
        dbit  <= '0;
        dslot <= (dslot == ns_last) ? '0 : dslot + 1'b1;
      end else begin
        dbit <= dbit + 1'b1;
      end
    end else if (!running) begin
      dslot <= delayed ? ns_last : '0;
      dbit  <= delayed ? s_last  : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ws_out <= 1'b0;
    else if (launch) ws_out <= emit ? (ws_raw ^ cfg_q.fs_inv) : cfg_q.fs_inv;
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> ((k_q <= ns_last) && (dslot <= ns_last))); // R4

endmodule

// File: rtl/pcm_ser_data.sv
module pcm_ser_data
  import pcm_ser_pkg::*;
#(
  parameter int TDM_SLOTS = 8,
  parameter int KW        = 3,
  parameter int CW        = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic                running,
  input  logic                start,
  input  cfg_t                cfg_q,
  input  logic [CW-1:0]       chans_q,
  input  logic [KW-1:0]       dslot,
  input  logic [POS_W-1:0]    dbit,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                sd_out,
  output logic                underflow
);

  logic [SAMPLE_W-1:0] cur_word;
  logic                cur_act;
  logic                emit;
  logic [CW-1:0]       nch_cap;
  logic [CW-1:0]       nch;
  logic                act;
  logic                first;
  logic [POS_W-1:0]    wl;
  logic [POS_W-1:0]    off;
  logic [POS_W-1:0]    rel;
  logic                inr;
  logic [SAMPLE_W-1:0] in_word;
  logic [SAMPLE_W-1:0] src_word;
  logic                src_act;
  logic                sd_next;
  logic                take;

  assign emit = running | start;

  always_comb begin
    nch_cap  = (cfg_q.fmt == FMT_TDM) ? CW'(TDM_SLOTS) : CW'(2);
    nch      = (chans_q > nch_cap) ? nch_cap : chans_q;
    act      = CW'(dslot) < nch;
    first    = (dbit == '0);
    wl       = word_last(cfg_q);
    off      = (cfg_q.fmt == FMT_RIGHT) ? (slot_last(cfg_q) - wl) : '0;
    rel      = dbit - off;
    inr      = (dbit >= off) && (rel <= wl);
    in_word  = s_valid ? s_data : '0;
    src_word = first ? in_word : cur_word;
    src_act  = first ? act : cur_act;
    sd_next  = src_act & inr & src_word[wl - rel];
    take     = launch & emit & first & act;
  end

  assign s_ready = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_out   <= 1'b0;
      cur_word <= '0;
      cur_act  <= 1'b0;
    end else begin
      if (launch) sd_out <= emit ? sd_next : 1'b0;
      if (launch && emit && first) begin
        cur_word <= in_word;
        cur_act  <= act;
      end else if (!running) begin
        cur_act  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) underflow <= 1'b0;
    else     underflow <= (underflow & ~start) | (take & ~s_valid);
  end

  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underflow && !start) |=> underflow); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (launch && !emit) |=> !sd_out); // R11

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready); // R9

endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
  import pcm_ser_pkg::*;
#(
  parameter int TDM_SLOTS = 8,
  parameter int CHAN_W    = $clog2(TDM_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [1:0]          cfg_format,
  input  logic [1:0]          cfg_word,
  input  logic [1:0]          cfg_slot,
  input  logic [CHAN_W-1:0]   cfg_chans,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_fs_inv,
  input  logic                bclk,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                sd_out,
  output logic                ws_out,
  output logic                underflow
);

  localparam int KW = (TDM_SLOTS > 2) ? $clog2(TDM_SLOTS) : 1;

  cfg_t             cfg_in;
  cfg_t             cfg_q;
  logic [CHAN_W-1:0] chans_q;
  logic             launch;
  logic             running;
  logic             start;
  logic             frame_last;
  logic [KW-1:0]    dslot;
  logic [POS_W-1:0] dbit;

  assign cfg_in = '{fmt: fmt_e'(cfg_format), word_code: cfg_word,
                    slot_code: cfg_slot, bclk_inv: cfg_bclk_inv,
                    fs_inv: cfg_fs_inv};

  pcm_ser_ctrl #(.CW(CHAN_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .cfg_in(cfg_in),
    .chans_in(cfg_chans), .bclk(bclk), .frame_last(frame_last),
    .cfg_q(cfg_q), .chans_q(chans_q), .launch(launch),
    .running(running), .start(start)
  );

  pcm_ser_slots #(.TDM_SLOTS(TDM_SLOTS), .KW(KW)) u_slots (
    .clk(clk), .rst(rst), .launch(launch), .running(running),
    .start(start), .cfg_q(cfg_q), .frame_last(frame_last),
    .dslot(dslot), .dbit(dbit), .ws_out(ws_out)
  );

  pcm_ser_data #(.TDM_SLOTS(TDM_SLOTS), .KW(KW), .CW(CHAN_W)) u_data (
    .clk(clk), .rst(rst), .launch(launch), .running(running),
    .start(start), .cfg_q(cfg_q), .chans_q(chans_q), .dslot(dslot),
    .dbit(dbit), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sd_out(sd_out), .underflow(underflow)
  );

endmodule

// File: tb/pcm_serializer_test.sv
`timescale 1ns/1ps
module pcm_serializer_test;

  localparam int TDM_SLOTS = 8;
  localparam int CW = $clog2(TDM_SLOTS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    fmt = 2'd0, wc = 2'd0, sc = 2'd0;
  logic [CW-1:0] chans = CW'(2);
  logic          binv = 1'b0, finv = 1'b0;
  logic          bclk = 1'b0;
  logic          s_valid = 1'b0;
  logic [31:0]   s_data = '0;
  logic          s_ready, sd_out, ws_out, underflow;

  always #2 clk = ~clk;

  pcm_serializer #(.TDM_SLOTS(TDM_SLOTS)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_format(fmt),
    .cfg_word(wc), .cfg_slot(sc), .cfg_chans(chans),
    .cfg_bclk_inv(binv), .cfg_fs_inv(finv), .bclk(bclk),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .sd_out(sd_out), .ws_out(ws_out), .underflow(underflow)
  );

  int          vectors = 0;
  int          errors  = 0;
  logic [1:0]  exp_q[$];
  logic [31:0] src_q[$];
  logic        hs = 1'b0;
  logic        gen_inv = 1'b0;
  string       cur_req = "";
  event        smp_ev;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit clock: launch edge, then receiver sample edge
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      bclk = gen_inv;
      repeat (4) @(negedge clk);
      bclk = ~gen_inv;
      -> smp_ev;
    end
  end

  // monitor: compare serial output at each receiver sample edge
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check({cur_req, " ws/sd"}, {30'd0, ws_out, sd_out}, {30'd0, e});
      end
    end
  end

  // sample source
  always @(posedge clk) hs <= s_valid && s_ready;
  initial begin
    forever begin
      @(negedge clk);
      if (hs && src_q.size() > 0) src_q.delete(0);
      s_valid = (src_q.size() > 0);
      s_data  = s_valid ? src_q[0] : '0;
    end
  end

  task automatic run(string tag, logic [1:0] f, logic [1:0] w, logic [1:0] s,
                     int ch, bit bi, bit fi, int frames, int nprov, bit glitch);
    int W, S, NS, nch, F, d, total, off;
    logic [31:0] smp[$];
    logic [1:0]  exp_l[$];
    W  = 8 * (int'(w) + 1);
    S  = 8 * ((s > w ? int'(s) : int'(w)) + 1);
    NS = (f == 2'd3) ? TDM_SLOTS : 2;
    nch = (ch > NS) ? NS : ch;
    F  = NS * S;
    d  = (f == 2'd0) ? 1 : 0;
    off = (f == 2'd2) ? S - W : 0;
    total = frames * nch;
    enable = 1'b0;
    fmt = f; wc = w; sc = s; chans = CW'(ch); binv = bi; finv = fi;
    gen_inv = bi;
    repeat (3) @(smp_ev);
    for (int i = 0; i < total; i++) begin
      logic [31:0] v;
      v = $urandom;
      if (W < 32) v = v & ((32'd1 << W) - 1);
      smp.push_back(v);
      if (i < nprov) src_q.push_back(v);
    end
    for (int r = 0; r < frames; r++) begin
      for (int fp = 0; fp < F; fp++) begin
        int g, rr, j, q;
        logic bv, wv;
        g = fp - d; rr = r;
        if (g < 0) begin g += F; rr = r - 1; end
        j = g / S; q = g % S; bv = 1'b0;
        if (rr >= 0 && j < nch && q >= off && (q - off) < W) begin
          int idx;
          idx = rr * nch + j;
          if (idx < nprov) bv = smp[idx][W - 1 - (q - off)];
        end
        wv = (f == 2'd3) ? (fp == 0) : (fp >= S);
        exp_l.push_back({wv ^ fi, bv});
      end
    end
    for (int i = 0; i < 4; i++) exp_l.push_back({fi, 1'b0});
    cur_req = tag;
    @(smp_ev);
    @(posedge clk);
    foreach (exp_l[i]) exp_q.push_back(exp_l[i]);
    enable = 1'b1;
    if (glitch) begin
      repeat (5) @(smp_ev);
      fmt = ~f; wc = ~w; chans = CW'(1); finv = ~fi; binv = ~bi;
    end
    while (exp_q.size() > 7) @(smp_ev);
    enable = 1'b0;
    fmt = f; wc = w; chans = CW'(ch); finv = fi; binv = bi;
    while (exp_q.size() > 0) @(smp_ev);
    @(smp_ev);
    check({tag, " R9 samples taken"}, src_q.size(), 0);
    check({tag, " R10 underflow flag"}, {31'd0, underflow}, {31'd0, nprov < total});
    src_q.delete();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("reset R11 sd_out", {31'd0, sd_out}, 32'd0);
    check("reset R11 ws_out", {31'd0, ws_out}, 32'd0);
    check("reset R10 underflow", {31'd0, underflow}, 32'd0);
    check("reset R9 s_ready", {31'd0, s_ready}, 32'd0);
    rst = 1'b0;
    run("R1 R5 R11 i2s 16/16 stereo",   2'd0, 2'd1, 2'd1, 2, 0, 0, 3, 6, 0);
    run("R2 R5 left 24 in 32",          2'd1, 2'd2, 2'd3, 2, 0, 0, 3, 6, 0);
    run("R3 R5 right 16 in 32",         2'd2, 2'd1, 2'd3, 2, 0, 0, 3, 6, 0);
    run("R4 tdm 8-bit 3 of 8",          2'd3, 2'd0, 2'd0, 3, 0, 0, 3, 9, 0);
    run("R6 i2s mono",                  2'd0, 2'd1, 2'd1, 1, 0, 0, 3, 3, 0);
    run("R6 left chans capped",         2'd1, 2'd0, 2'd1, 5, 0, 0, 2, 4, 0);
    run("R7 R8 inverted left 32",       2'd1, 2'd3, 2'd3, 2, 1, 1, 2, 4, 0);
    run("R10 i2s underflow",            2'd0, 2'd1, 2'd1, 2, 0, 0, 3, 4, 0);
    run("R10 R11 restart clears flag",  2'd1, 2'd0, 2'd1, 2, 0, 0, 2, 4, 0);
    run("R12 tdm cfg frozen",           2'd3, 2'd1, 2'd1, 5, 0, 0, 2, 10, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule